// File: doc/BRIEF.md
# Overscan Border and Blanking Control

This block sits just ahead of the analog output stage of a video pipeline. It decides, pixel by pixel, whether the output carries the incoming RGB data, a programmable border color, or black, and whether the analog stage must apply its blanking pedestal. The blank that drives these decisions comes from one of two active-low inputs: a VGA-path blank or a system-path blank. A mode bit picks the input.

The blank and the overscan strobe are captured together into one sample stage. In VGA mode they are captured on every rising clock edge. Otherwise they are captured only in cycles where a chosen clock enable is high. A select bit picks one of two enables. When overscan is enabled, a high strobe during blanking replaces the pixel with the border color. Any other blanked pixel is forced to zero. The border color is held in three 8-bit registers written through a small register port.

Top module: `ovs_border_ctrl`

## Requirements
- R1: After reset, pix_o and pedestal_o are 0, the sampled blank is inactive, the sampled strobe is 0, and all three border color registers are 0.
- R2: The blank source is vga_blank_ni when vga_mode_i is 1, and sys_blank_ni when vga_mode_i is 0. Both are active low.
- R3: Blank and strobe are captured at every clock edge in VGA mode. In non-VGA mode they are captured only at edges where the selected enable is high: lclk_en_i when sel_lclk_i is 1, vclk_en_i when it is 0. At other edges they hold their value.
- R4: If ovs_en_i is 1, the sampled blank is low and the sampled strobe is high, the next pix_o is the border color {red, green, blue}, with red in bits 23:16 and blue in bits 7:0.
- R5: If ovs_en_i is 1, the next pedestal_o is 1 exactly when both the sampled blank and the sampled strobe are low.
- R6: If ovs_en_i is 0, the next pedestal_o is 1 exactly when the sampled blank is low, and pix_o is then 0 whatever the strobe is.
- R7: If ovs_en_i is 1, the sampled blank is low and the sampled strobe is low, the next pix_o is 0.
- R8: While the sampled blank is high, the next pix_o equals pix_i from the same edge (one register of latency), pedestal_o is 0, and the strobe has no effect.
- R9: A write with reg_we_i set loads reg_wdata_i into the red register at address 0, green at address 1, and blue at address 2. Address 3 changes no register. A written value is used from the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vga_mode_i | input | 1 | 1: VGA blank source and capture at every edge |
| ovs_en_i | input | 1 | Overscan border enable |
| sel_lclk_i | input | 1 | Non-VGA capture enable select (1: lclk_en_i) |
| vclk_en_i | input | 1 | Capture enable, option 0 |
| lclk_en_i | input | 1 | Capture enable, option 1 |
| sys_blank_ni | input | 1 | System blank, active low |
| vga_blank_ni | input | 1 | VGA blank, active low |
| ovs_i | input | 1 | Overscan strobe |
| reg_we_i | input | 1 | Border register write strobe |
| reg_addr_i | input | 2 | Border register address |
| reg_wdata_i | input | 8 | Border register write data |
| pix_i | input | 24 | Incoming RGB pixel, red in the top byte |
| pix_o | output | 24 | Output RGB pixel |
| pedestal_o | output | 1 | Blanking pedestal enable for the analog stage |

## Verification
The output decision depends on only two state bits. If either is captured at the wrong edge, the wrong pixel class or pedestal value appears at the ports on the edge after the faulty capture. If either holds when it should update, that error also stays visible for as long as the input levels differ from the held value. The bench sweeps every combination of the mode, enable, select, blank and strobe inputs and compares each edge against a model, so a wrong capture or a wrong source shows up within one cycle. A wrong color register or address decode corrupts the border color the next time a border pixel is produced, and register writes are each followed by a border pixel that checks them.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  localparam int unsigned CW  = 8;
  localparam int unsigned NCH = 3;
  localparam int unsigned AW  = 2;
  localparam int unsigned PW  = CW * NCH;

  typedef enum logic [1:0] {
    PIX_PASS   = 2'd0,
    PIX_BORDER = 2'd1,
    PIX_BLACK  = 2'd2
  } pix_sel_e;
endpackage

// File: rtl/ovs_color_regs.sv
module ovs_color_regs #(
  parameter int unsigned CW  = ovs_pkg::CW,
  parameter int unsigned NCH = ovs_pkg::NCH,
  parameter int unsigned AW  = ovs_pkg::AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [CW-1:0]     wdata_i,
  output logic [CW*NCH-1:0] color_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= '0;
      else if (we_i && addr_i == AW'(c))          q <= wdata_i;
    end
    // channel 0 lands in the most significant byte
    assign color_o[(NCH-1-c)*CW +: CW] = q;
  end
endmodule

// File: rtl/ovs_sampler.sv
module ovs_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vga_mode_i,
  input  logic sel_lclk_i,
  input  logic vclk_en_i,
  input  logic lclk_en_i,
  input  logic sys_blank_ni,
  input  logic vga_blank_ni,
  input  logic ovs_i,
  output logic blank_nq_o,
  output logic ovs_q_o
);
  logic smp_en, blank_src_n;

  always_comb begin
    blank_src_n = vga_mode_i ? vga_blank_ni : sys_blank_ni;
    if (vga_mode_i) smp_en = 1'b1;
    else            smp_en = sel_lclk_i ? lclk_en_i : vclk_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blank_nq_o <= 1'b1;
      ovs_q_o    <= 1'b0;
    end else if (smp_en) begin
      blank_nq_o <= blank_src_n;
      ovs_q_o    <= ovs_i;
    end
  end
endmodule

// File: rtl/ovs_out_stage.sv
module ovs_out_stage #(
  parameter int unsigned PW = ovs_pkg::PW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ovs_en_i,
  input  logic          blank_nq_i,
  input  logic          ovs_q_i,
  input  logic [PW-1:0] pix_i,
  input  logic [PW-1:0] border_i,
  output logic [PW-1:0] pix_o,
  output logic          pedestal_o
);
  import ovs_pkg::*;

  pix_sel_e sel;
  logic     ped_d;
  logic [PW-1:0] pix_d;

  always_comb begin
    sel   = PIX_PASS;
    ped_d = 1'b0;
    if (!blank_nq_i) begin
      if (ovs_en_i && ovs_q_i) begin
        sel = PIX_BORDER;
      end else begin
        sel   = PIX_BLACK;
        ped_d = 1'b1;
      end
    end
    unique case (sel)
      PIX_BORDER: pix_d = border_i;
      PIX_BLACK:  pix_d = '0;
      default:    pix_d = pix_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o      <= '0;
      pedestal_o <= 1'b0;
    end else begin
      pix_o      <= pix_d;
      pedestal_o <= ped_d;
    end
  end
endmodule

// File: rtl/ovs_border_ctrl.sv
module ovs_border_ctrl (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        vga_mode_i,
  input  logic        ovs_en_i,
  input  logic        sel_lclk_i,
  input  logic        vclk_en_i,
  input  logic        lclk_en_i,
  input  logic        sys_blank_ni,
  input  logic        vga_blank_ni,
  input  logic        ovs_i,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  input  logic [23:0] pix_i,
  output logic [23:0] pix_o,
  output logic        pedestal_o
);
  import ovs_pkg::*;

  logic          blank_nq, ovs_q;
  logic [PW-1:0] border;

  ovs_color_regs #(.CW(CW), .NCH(NCH), .AW(AW)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .color_o (border)
  );

  ovs_sampler i_smp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vga_mode_i   (vga_mode_i),
    .sel_lclk_i   (sel_lclk_i),
    .vclk_en_i    (vclk_en_i),
    .lclk_en_i    (lclk_en_i),
    .sys_blank_ni (sys_blank_ni),
    .vga_blank_ni (vga_blank_ni),
    .ovs_i        (ovs_i),
    .blank_nq_o   (blank_nq),
    .ovs_q_o      (ovs_q)
  );

  ovs_out_stage #(.PW(PW)) i_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ovs_en_i   (ovs_en_i),
    .blank_nq_i (blank_nq),
    .ovs_q_i    (ovs_q),
    .pix_i      (pix_i),
    .border_i   (border),
    .pix_o      (pix_o),
    .pedestal_o (pedestal_o)
  );
endmodule

// File: rtl/ovs_border_ctrl_chk.sv
module ovs_border_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        vga_mode_i,
  input logic        ovs_en_i,
  input logic        sel_lclk_i,
  input logic        vclk_en_i,
  input logic        lclk_en_i,
  input logic [23:0] pix_i,
  input logic [23:0] pix_o,
  input logic        pedestal_o,
  input logic        blank_nq,
  input logic        ovs_q,
  input logic [23:0] border
);
  AST_HOLD_OFF_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!vga_mode_i && !(sel_lclk_i ? lclk_en_i : vclk_en_i)) |-> ($stable(blank_nq) && $stable(ovs_q))); // R3

  AST_BORDER_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ovs_en_i && ovs_q && !blank_nq) |-> (pix_o == $past(border) && !pedestal_o)); // R4

  AST_PED_ONLY_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pedestal_o |-> $past(!blank_nq)); // R5

  AST_NO_OVS_BLACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!ovs_en_i && !blank_nq) |-> (pedestal_o && pix_o == 24'd0)); // R6

  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(blank_nq) |-> (pix_o == $past(pix_i) && !pedestal_o)); // R8
endmodule

bind ovs_border_ctrl ovs_border_ctrl_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vga_mode_i (vga_mode_i),
  .ovs_en_i   (ovs_en_i),
  .sel_lclk_i (sel_lclk_i),
  .vclk_en_i  (vclk_en_i),
  .lclk_en_i  (lclk_en_i),
  .pix_i      (pix_i),
  .pix_o      (pix_o),
  .pedestal_o (pedestal_o),
  .blank_nq   (blank_nq),
  .ovs_q      (ovs_q),
  .border     (border)
);

// File: tb/test_ovs_border_ctrl.sv
module test_ovs_border_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vga_mode = 0, ovs_en = 0, sel_lclk = 0, vclk_en = 0, lclk_en = 0;
  logic sys_b = 1, vga_b = 1, ovs = 0, we = 0;
  logic [1:0]  addr = 0;
  logic [7:0]  wdata = 0;
  logic [23:0] pix_in = 0, pix_out;
  logic        ped;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  bit        m_bn = 1, m_ov = 0, m_ped = 0;
  logic [7:0]  m_col [3] = '{8'd0, 8'd0, 8'd0};
  logic [23:0] m_pix = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovs_border_ctrl i_ovs_border_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .vga_mode_i(vga_mode), .ovs_en_i(ovs_en),
    .sel_lclk_i(sel_lclk), .vclk_en_i(vclk_en), .lclk_en_i(lclk_en),
    .sys_blank_ni(sys_b), .vga_blank_ni(vga_b), .ovs_i(ovs),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .pix_i(pix_in), .pix_o(pix_out), .pedestal_o(ped)
  );

  task automatic check(string req, logic [24:0] act, logic [24:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // inputs already driven at negedge; advance one edge and compare to model
  task automatic step(string tag);
    string req;
    bit en;
    logic [23:0] e_pix;
    bit e_ped;
    if (m_bn) begin
      e_pix = pix_in; e_ped = 0; req = "R8";
    end else if (ovs_en && m_ov) begin
      e_pix = {m_col[0], m_col[1], m_col[2]}; e_ped = 0; req = "R4";
    end else begin
      e_pix = 0; e_ped = 1; req = ovs_en ? "R5 R7" : "R6";
    end
    en = vga_mode ? 1'b1 : (sel_lclk ? lclk_en : vclk_en);
    @(posedge clk);
    #1;
    m_pix = e_pix; m_ped = e_ped;
    if (we && addr != 2'd3) m_col[addr] = wdata;
    if (en) begin
      m_bn = vga_mode ? vga_b : sys_b;
      m_ov = ovs;
    end
    check({req, " R2 R3 ", tag}, {ped, pix_out}, {m_ped, m_pix});
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check("R1 reset", {ped, pix_out}, 25'd0);
    rst_n = 1;
    @(negedge clk);
    // R1: border regs start at zero -> a border pixel is black
    vga_mode = 1; vga_b = 0; ovs = 1; ovs_en = 1;
    step("R1");
    pix_in = 24'hABCDEF;
    step("R1");
    check("R1 border", {1'b0, pix_out}, 25'd0);
    // R9: register port, including the dead address
    for (int a = 0; a < 4; a++) begin
      we = 1; addr = 2'(a); wdata = 8'h11 * 8'(a + 1);
      step("R9");
      we = 0;
      step("R9");
    end
    // R9 readback: border pixel must equal {11,22,33}
    check("R9 colors", {1'b0, pix_out}, 25'h112233);
    // exhaustive sweep over control/strobe/blank inputs
    for (int rep = 0; rep < 3; rep++) begin
      for (int i = 0; i < 256; i++) begin
        logic [7:0] v;
        v = 8'(i) ^ 8'(rep * 8'h6B);
        {vga_mode, ovs_en, sel_lclk, vclk_en, lclk_en, sys_b, vga_b, ovs} = v;
        pix_in = {8'(i), ~8'(i), 8'(i) ^ 8'h5A};
        we = (i % 37) == 0; addr = 2'(i); wdata = 8'(i * 3);
        step("sweep");
      end
    end
    we = 0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule